// File: doc/BRIEF.md
# Banked Digital I/O Event Controller

The block drives and senses 24 general-purpose lines, grouped as three 8-bit ports, through a window of eight byte registers. Each port has an output latch that a bus write loads. A read of a port returns the complement of the line levels, as an inverting input buffer would. After reset the block works in a plain mode where only the port registers exist.

Software can enable an extended register set. To do so, the very first bus accesses after reset must be four writes of a fixed key sequence to the key offset. The extended set is reached through a bank field in a shared control register, which also holds a write-inhibit bit for each port. The banks provide:
- a per-port input debounce filter, with a programmable duration and tick divider;
- per-port change detection, with sticky flags and a single interrupt output.

Top module: `dio_event_ctrl`

## Requirements
- R1: After reset, port_out is 0, bus_rdata is 00h, irq is 0 and the block is in plain mode.
- R2: A write to offset 0, 1 or 2 loads the output latch of port 0, 1 or 2 (port p drives port_out[8p+7:8p]). A read of those offsets returns the bitwise inverse of that port's filtered input. With debounce off, the filtered input is pin_in delayed by two clocks. Read data appears on bus_rdata the cycle after bus_rd and holds until the next read.
- R3: Extended mode is entered only if the first four bus accesses after reset are writes of 07h, 0Dh, 06h, 12h, in that order, to offset 5. Any other access before the sequence completes, including a wrong key byte, leaves the block in plain mode until the next reset.
- R4: In extended mode, offset 7 is a control register at every bank. Bits 7:6 select the bank (00 ports, 01 event, 10 debounce, 11 none) and bits 2:0 are the per-port write-inhibit bits; it reads back as written. In plain mode, writes to offset 7 have no effect and reads return 00h.
- R5: In extended mode with bank 00, a port write is discarded when that port's inhibit bit (control bit p) is 1.
- R6: With bank 11 selected, writes to offsets 0 to 6 have no effect and reads of them return 00h.
- R7: In bank 10, offset 0 bits 2:0 enable debounce per port, offset 1 is the duration D and offset 3 is the divider V. A tick occurs every V+1 clocks. On an enabled port, a line's filtered value takes a new level only after the level has differed on D consecutive ticks (D of 0 acts as 1). A shorter pulse is dropped.
- R8: In bank 01, offset 0 bits 2:0 enable events per port. A change of any filtered line on an enabled port sets that port's sticky flag, read at offset 1 bits 2:0. Writing 1 to a flag bit at offset 1 clears it. A change on a port whose event enable is 0 sets no flag.
- R9: irq is 1 exactly when some flag is set on a port whose event enable is 1; it lags the flag by one clock and also reads as bit 7 of bank 01 offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Line levels, port p on bits 8p+7:8p |
| port_out | output | 24 | Output latches, port p on bits 8p+7:8p |
| irq | output | 1 | Event interrupt |

## Verification
The unlock sequence is tried in three forms, and each is judged by whether the control register reads back:
- preceded by a read;
- with a wrong third key;
- alone after reset.

Random port writes under random inhibit masks separate plain latching from discarded writes. Random line levels read back confirm the inversion. The debounce filter gets a two-cycle glitch, a held change checked both early and late, and a zero duration, which together separate the tick counting from plain sampling. Changes on enabled and disabled ports, flag clears and enable changes separate sticky flag capture from the interrupt gating.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic [1:0] {
    BANK_PORTS    = 2'b00,
    BANK_EVENT    = 2'b01,
    BANK_DEBOUNCE = 2'b10,
    BANK_NONE     = 2'b11
  } bank_e;

  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned KEY_LEN  = 4;
  localparam logic [2:0] OFF_KEY   = 3'd5;
  localparam logic [2:0] OFF_CTRL  = 3'd7;
  localparam logic [2:0] OFF_EVEN  = 3'd0;
  localparam logic [2:0] OFF_EFLG  = 3'd1;
  localparam logic [2:0] OFF_DBEN  = 3'd0;
  localparam logic [2:0] OFF_DBDUR = 3'd1;
  localparam logic [2:0] OFF_DBDIV = 3'd3;

  function automatic logic [7:0] key_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    key_byte = 8'h07;
      2'd1:    key_byte = 8'h0D;
      2'd2:    key_byte = 8'h06;
      default: key_byte = 8'h12;
    endcase
  endfunction
endpackage

// File: rtl/dio_unlock_fsm.sv
module dio_unlock_fsm
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_data,
  output logic              extended
);
  typedef enum logic [1:0] {ST_ARMED, ST_LOCKED, ST_OPEN} ustate_e;

  ustate_e    state;
  logic [1:0] step;
  logic       key_hit;

  assign key_hit  = acc_wr && !acc_rd && (acc_addr == OFF_KEY) && (acc_data == key_byte(step));
  assign extended = (state == ST_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ARMED;
      step  <= '0;
    end else if (state == ST_ARMED && (acc_wr || acc_rd)) begin
      if (!key_hit) begin
        state <= ST_LOCKED;
      end else if (step == 2'(KEY_LEN - 1)) begin
        state <= ST_OPEN;
      end else begin
        step <= step + 2'd1;
      end
    end
  end

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCKED) |=> (state == ST_LOCKED));
  assert_open_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    extended |=> extended);
  assert_bad_access_locks_R3: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ARMED) && acc_rd) |=> (state == ST_LOCKED));
endmodule

// File: rtl/dio_debounce.sv
module dio_debounce #(
  parameter int unsigned NPORTS = 3,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS*PORT_W-1:0] raw,
  input  logic [NPORTS-1:0]        port_en,
  input  logic [CNT_W-1:0]         dur,
  input  logic [DIV_W-1:0]         div,
  output logic [NPORTS*PORT_W-1:0] filt
);
  localparam int unsigned NLINES = NPORTS * PORT_W;

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  logic [CNT_W-1:0] last;

  assign tick = (div_cnt >= div);
  assign last = (dur == '0) ? '0 : dur - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || tick) div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    localparam int unsigned P = l / PORT_W;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt     <= '0;
        filt[l] <= 1'b0;
      end else if (!port_en[P]) begin
        cnt     <= '0;
        filt[l] <= raw[l];
      end else if (raw[l] == filt[l]) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt >= last) begin
          filt[l] <= raw[l];
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (rst)
      (port_en[P] && !tick) |=> $stable(filt[l]));
  end
endmodule

// File: rtl/dio_event_sense.sv
module dio_event_sense #(
  parameter int unsigned NPORTS = 3,
  parameter int unsigned PORT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS*PORT_W-1:0] filt,
  input  logic [NPORTS-1:0]        ev_en,
  input  logic [NPORTS-1:0]        clr,
  output logic [NPORTS-1:0]        flags,
  output logic                     irq
);
  logic [NPORTS*PORT_W-1:0] filt_q;
  logic [NPORTS-1:0]        chg;

  for (genvar p = 0; p < NPORTS; p++) begin : g_chg
    assign chg[p] = |(filt[p*PORT_W +: PORT_W] ^ filt_q[p*PORT_W +: PORT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= '0;
      flags  <= '0;
      irq    <= 1'b0;
    end else begin
      filt_q <= filt;
      flags  <= (flags & ~clr) | (chg & ev_en);
      irq    <= |(flags & ev_en);
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (flags[p] && !clr[p]) |=> flags[p]);
    assert_no_flag_when_off_R8: assert property (@(posedge clk) disable iff (rst)
      (!flags[p] && !ev_en[p]) |=> !flags[p]);
  end

  assert_irq_needs_source_R9: assert property (@(posedge clk) disable iff (rst)
    ((flags & ev_en) == '0) |=> !irq);
endmodule

// File: rtl/dio_event_ctrl.sv
module dio_event_ctrl
  import dio_pkg::*;
#(
  parameter int unsigned NPORTS = 3,
  parameter int unsigned PORT_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [PORT_W-1:0]        bus_wdata,
  output logic [PORT_W-1:0]        bus_rdata,
  input  logic [NPORTS*PORT_W-1:0] pin_in,
  output logic [NPORTS*PORT_W-1:0] port_out,
  output logic                     irq
);
  localparam int unsigned NLINES  = NPORTS * PORT_W;
  localparam int unsigned CTRL_GAP = PORT_W - 2 - NPORTS;
  localparam int unsigned FLG_GAP  = PORT_W - 1 - NPORTS;
  localparam int unsigned EN_GAP   = PORT_W - NPORTS;

  logic                 extended;
  bank_e                bank;
  logic [NPORTS-1:0]    inhibit;
  logic [NPORTS-1:0]    ev_en;
  logic [NPORTS-1:0]    db_en;
  logic [CNT_W-1:0]     db_dur;
  logic [DIV_W-1:0]     db_div;
  logic [NLINES-1:0]    pin_s;
  logic [NLINES-1:0]    filt;
  logic [NPORTS-1:0]    flags;
  logic [NPORTS-1:0]    clr;
  logic                 ctrl_wr;
  logic                 bank_wr;
  logic [PORT_W-1:0]    rd_val;

  dio_unlock_fsm u_unlock (
    .clk      (clk),
    .rst      (rst),
    .acc_wr   (bus_wr),
    .acc_rd   (bus_rd),
    .acc_addr (bus_addr),
    .acc_data (bus_wdata),
    .extended (extended)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_s <= '0;
    else     pin_s <= pin_in;
  end

  dio_debounce #(
    .NPORTS (NPORTS),
    .PORT_W (PORT_W),
    .CNT_W  (CNT_W),
    .DIV_W  (DIV_W)
  ) u_debounce (
    .clk     (clk),
    .rst     (rst),
    .raw     (pin_s),
    .port_en (db_en),
    .dur     (db_dur),
    .div     (db_div),
    .filt    (filt)
  );

  dio_event_sense #(
    .NPORTS (NPORTS),
    .PORT_W (PORT_W)
  ) u_events (
    .clk   (clk),
    .rst   (rst),
    .filt  (filt),
    .ev_en (ev_en),
    .clr   (clr),
    .flags (flags),
    .irq   (irq)
  );

  assign ctrl_wr = bus_wr && extended && (bus_addr == OFF_CTRL);
  assign bank_wr = bus_wr && extended && (bus_addr != OFF_CTRL);
  assign clr     = (bank_wr && bank == BANK_EVENT && bus_addr == OFF_EFLG)
                   ? bus_wdata[NPORTS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank    <= BANK_PORTS;
      inhibit <= '0;
      ev_en   <= '0;
      db_en   <= '0;
      db_dur  <= '0;
      db_div  <= '0;
    end else if (ctrl_wr) begin
      bank    <= bank_e'(bus_wdata[PORT_W-1:PORT_W-2]);
      inhibit <= bus_wdata[NPORTS-1:0];
    end else if (bank_wr) begin
      case (bank)
        BANK_EVENT: begin
          if (bus_addr == OFF_EVEN) ev_en <= bus_wdata[NPORTS-1:0];
        end
        BANK_DEBOUNCE: begin
          if (bus_addr == OFF_DBEN)  db_en  <= bus_wdata[NPORTS-1:0];
          if (bus_addr == OFF_DBDUR) db_dur <= CNT_W'(bus_wdata);
          if (bus_addr == OFF_DBDIV) db_div <= DIV_W'(bus_wdata);
        end
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_latch
    logic hit;
    assign hit = bus_wr && (bus_addr == ADDR_W'(p)) &&
                 (!extended || (bank == BANK_PORTS && !inhibit[p]));

    always_ff @(posedge clk) begin
      if (rst)      port_out[p*PORT_W +: PORT_W] <= '0;
      else if (hit) port_out[p*PORT_W +: PORT_W] <= bus_wdata;
    end

    assert_inhibit_blocks_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && extended && bank == BANK_PORTS && bus_addr == ADDR_W'(p) && inhibit[p])
      |=> $stable(port_out[p*PORT_W +: PORT_W]));
    assert_dead_bank_write_R6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && extended && bank == BANK_NONE && bus_addr != OFF_CTRL)
      |=> $stable(port_out[p*PORT_W +: PORT_W]));
  end

  always_comb begin
    rd_val = '0;
    if (!extended || bank == BANK_PORTS) begin
      for (int p = 0; p < NPORTS; p++) begin
        if (bus_addr == ADDR_W'(p)) rd_val = ~filt[p*PORT_W +: PORT_W];
      end
    end
    if (extended) begin
      if (bus_addr == OFF_CTRL) begin
        rd_val = {bank, {CTRL_GAP{1'b0}}, inhibit};
      end else begin
        case (bank)
          BANK_EVENT: begin
            if (bus_addr == OFF_EVEN) rd_val = {{EN_GAP{1'b0}}, ev_en};
            if (bus_addr == OFF_EFLG) rd_val = {irq, {FLG_GAP{1'b0}}, flags};
          end
          BANK_DEBOUNCE: begin
            if (bus_addr == OFF_DBEN)  rd_val = {{EN_GAP{1'b0}}, db_en};
            if (bus_addr == OFF_DBDUR) rd_val = PORT_W'(db_dur);
            if (bus_addr == OFF_DBDIV) rd_val = PORT_W'(db_div);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assert_plain_ctrl_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !extended && bus_addr == OFF_CTRL) |=> (bus_rdata == '0));
  assert_dead_bank_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && extended && bank == BANK_NONE && bus_addr != OFF_CTRL) |=> (bus_rdata == '0));
  assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/dio_event_ctrl_bench.sv
module dio_event_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = '0;
  logic [23:0] port_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dio_event_ctrl u_dio_event_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .port_out(port_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_key();
    wr(3'd5, 8'h07); wr(3'd5, 8'h0D); wr(3'd5, 8'h06); wr(3'd5, 8'h12);
  endtask

  function automatic logic [7:0] inv_port(input logic [23:0] pins, input int p);
    return ~pins[p*8 +: 8];
  endfunction

  function automatic logic [7:0] ctrl_word(input logic [1:0] b, input logic [2:0] inh);
    return {b, 3'b000, inh};
  endfunction

  initial begin
    logic [7:0]  v;
    logic [23:0] model;
    logic [2:0]  inh;
    void'($urandom(32'd4711));

    // Plain mode: a read before the key locks the block
    do_reset();
    chk("R1 port_out after reset", port_out, 24'h0);
    chk("R1 rdata after reset", bus_rdata, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    rd(3'd0, v);
    chk("R2 plain read inverted", v, 8'hFF);
    send_key();
    wr(3'd7, 8'h40);
    rd(3'd7, v);
    chk("R3 key after read stays plain", v, 8'h00);
    wr(3'd1, 8'hA5);
    chk("R2 plain write latch", port_out, 24'h00A500);

    // Wrong key byte locks too
    do_reset();
    wr(3'd5, 8'h07); wr(3'd5, 8'h0D); wr(3'd5, 8'h05);
    send_key();
    wr(3'd7, 8'h40);
    rd(3'd7, v);
    chk("R3 wrong key stays plain", v, 8'h00);
    chk("R4 plain ctrl write ignored, port0 writable", port_out, 24'h0);

    // Correct key
    do_reset();
    send_key();
    wr(3'd7, 8'h45);
    rd(3'd7, v);
    chk("R4 ctrl readback", v, 8'h45);
    wr(3'd7, ctrl_word(2'b00, 3'b000));

    // Random latch writes under random inhibit masks, random pin reads
    model = '0;
    for (int i = 0; i < 40; i++) begin
      int p;
      logic [7:0] d;
      p   = $urandom_range(0, 2);
      d   = 8'($urandom);
      inh = 3'($urandom);
      wr(3'd7, ctrl_word(2'b00, inh));
      wr(3'(p), d);
      if (!inh[p]) model[p*8 +: 8] = d;
      chk(inh[p] ? "R5 inhibited write" : "R2 latch write", port_out, model);
    end
    wr(3'd7, ctrl_word(2'b00, 3'b000));
    for (int i = 0; i < 10; i++) begin
      logic [23:0] pv;
      pv = 24'($urandom);
      @(negedge clk); pin_in = pv;
      repeat (3) @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        rd(3'(p), v);
        chk("R2 inverted pin read", v, inv_port(pv, p));
      end
    end
    wr(3'd7, ctrl_word(2'b01, 3'b000));
    rd(3'd1, v);
    chk("R8 no flags with events off", v, 8'h00);

    // Bank 11: no effect, reads zero
    wr(3'd7, ctrl_word(2'b11, 3'b000));
    wr(3'd0, ~model[7:0]);
    rd(3'd0, v);
    chk("R6 dead bank read", v, 8'h00);
    chk("R6 dead bank write", port_out, model);

    // Events
    @(negedge clk); pin_in = 24'h000000;
    repeat (4) @(negedge clk);
    wr(3'd7, ctrl_word(2'b01, 3'b000));
    wr(3'd1, 8'h07);
    wr(3'd0, 8'h02);
    rd(3'd0, v);
    chk("R8 event enable readback", v, 8'h02);
    @(negedge clk); pin_in = 24'h000001;
    repeat (5) @(negedge clk);
    rd(3'd1, v);
    chk("R8 change on disabled port no flag", v, 8'h00);
    chk("R9 irq low", irq, 1'b0);
    @(negedge clk); pin_in = 24'h000401;
    repeat (5) @(negedge clk);
    rd(3'd1, v);
    chk("R8 R9 flag and global bit", v, 8'h82);
    chk("R9 irq high", irq, 1'b1);
    @(negedge clk); pin_in = 24'h000001;
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h00);
    repeat (2) @(negedge clk);
    chk("R9 irq masked by enable", irq, 1'b0);
    rd(3'd1, v);
    chk("R8 flag sticky while masked", v, 8'h02);
    wr(3'd1, 8'h02);
    rd(3'd1, v);
    chk("R8 write-one clear", v, 8'h00);

    // Debounce on port 2: divider 3, duration 3
    wr(3'd7, ctrl_word(2'b10, 3'b000));
    wr(3'd3, 8'd3);
    wr(3'd1, 8'd3);
    wr(3'd0, 8'h04);
    rd(3'd1, v);
    chk("R7 duration readback", v, 8'd3);
    wr(3'd7, ctrl_word(2'b00, 3'b000));
    @(negedge clk); pin_in = 24'h010001;
    repeat (2) @(negedge clk); pin_in = 24'h000001;
    repeat (20) @(negedge clk);
    rd(3'd2, v);
    chk("R7 glitch rejected", v, 8'hFF);
    @(negedge clk); pin_in = 24'h800001;
    repeat (4) @(negedge clk);
    rd(3'd2, v);
    chk("R7 early read still old", v, 8'hFF);
    repeat (16) @(negedge clk);
    rd(3'd2, v);
    chk("R7 held change accepted", v, 8'h7F);
    wr(3'd7, ctrl_word(2'b10, 3'b000));
    wr(3'd3, 8'd0);
    wr(3'd1, 8'd0);
    wr(3'd7, ctrl_word(2'b00, 3'b000));
    @(negedge clk); pin_in = 24'h000001;
    repeat (5) @(negedge clk);
    rd(3'd2, v);
    chk("R7 zero duration acts as one", v, 8'hFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule